// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block turns the leading bytes of a fetched instruction into everything the datapath needs for that instruction. The instructions are 2 to 10 bytes long. The block is purely combinational and keeps no state. Ten instruction bytes come in as one flat vector. The decoder returns the following:

- the opcode nibbles and the register specifiers;
- the shift amount and the instruction length in bytes;
- two sign-extended 32-bit immediates, each taken from the byte offset that its opcode dictates;
- a set of control strobes for the register file, memory, operand select, result unit and address generator.

A fetch stage places the bytes at the current program counter on `bytes_i`. It adds `len_o` to the program counter to reach the next sequential instruction, and it routes the remaining outputs into the execute stage. Major opcodes 0xC through 0xE are not defined. They raise `illegal_o` and leave every strobe low, so a trap path can act on them before anything is written.

Top module: `ivd_decoder`

## Requirements
- R1: Byte k of the instruction sits at `bytes_i[8k+7:8k]`. The fields are taken as follows:
  - `major_o` = byte0[7:4] and `minor_o` = byte0[3:0];
  - `rd_o` = byte1[7:4] and `rs_o` = byte1[3:0];
  - `rz_o` = byte2[7:4] and `shamt_o` = byte2[3:0].
- R2: `len_o` depends on the major opcode:
  - 2 for 0x0, 0x1, 0x2, 0x3 and 0x8;
  - 3 for 0x9;
  - 6 for 0x4, 0x5, 0x6, 0x7 and 0xA;
  - 7 for 0xB;
  - 10 for 0xF;
  - 0 otherwise.
- R3: `imm_a_o` is the little-endian 32-bit word at bytes 3..6 when the major opcode is 0xB, and at bytes 2..5 for every other opcode. It is sign-extended from bit 31 to XLEN.
- R4: `imm_b_o` is the little-endian word at bytes 6..9 when the major opcode is 0xF, and at bytes 2..5 otherwise. It is sign-extended from bit 31.
- R5: `cls_o` is one-hot, and major opcodes 0xC to 0xE give zero. The bit for each major opcode is:

  | Bit | Major opcode | Meaning |
  |-----|--------------|---------|
  | 0 | 0x0 | return/stop |
  | 1 | 0x1 | register arithmetic |
  | 2 | 0x2 | register move |
  | 3 | 0x3 | register memory move |
  | 4 | 0x4 | control flow |
  | 5 | 0x5 | immediate arithmetic |
  | 6 | 0x6 | immediate move |
  | 7 | 0x7 | immediate memory move |
  | 8 | 0x8 to 0xB | address compute |
  | 9 | 0xF | compare-and-branch |
- R6: For memory moves (major 0x3 or 0x7), `store_o` is minor bit 3 and `load_o` is its inverse. Both are low for all other opcodes.
- R7: The remaining flags follow from the minor opcode:
  - `cond_o` is high for major 0x4 or 0xF unless the minor opcode is 0xE or 0xF;
  - `call_o` is major 0x4 with minor 0xE;
  - `ret_o` is major 0x0 with minor 0x1;
  - `stop_o` is major 0x0 with minor 0x0.
- R8: The address-generator enables are built from the minor opcode and the class:
  - `ag_src_o` is minor bit 0 for address-compute and move forms (majors 0x2, 0x3, 0x6, 0x7, 0x8 to 0xB), and it is forced high for majors 0x1 and 0x4;
  - `ag_idx_o` is minor bit 1 for those same forms;
  - `ag_disp_o` is minor bit 2 for those same forms, and it is forced high for majors 0x5 and 0xF.
- R9: `reg_we_o` is high for the following, and low for everything else:
  - arithmetic (0x1 and 0x5);
  - address compute;
  - loads;
  - register and immediate moves (0x2 and 0x6);
  - calls.

  `rd_port_o` is `rz_o` for address-compute forms and `rd_o` otherwise.
- R10: `fu_sel_o` has at most one bit set:
  - bit 0 selects the address generator, for address-compute and move forms;
  - bit 1 selects the multiplier, for arithmetic with minor 0x4 or 0x5;
  - bit 2 selects the shifter, for arithmetic with minor 0xC, 0xD or 0xE;
  - bit 3 selects the ALU, for all other arithmetic and for conditional forms.

  `use_imm_o` is high for majors 0x5, 0x6 and 0xF.
- R11: Majors 0xC to 0xE drive `illegal_o` high. They also force the following to zero: `len_o`, `cls_o`, `reg_we_o`, `load_o`, `store_o`, `use_imm_o`, `cond_o`, `fu_sel_o` and the three address-generator enables.
- R12: `mul_signed_o` is high only when the multiplier is selected with minor 0x5. `shift_left_o` is high only when the shifter is selected with minor 0xC. `shift_arith_o` is high only when the shifter is selected with minor 0xC or 0xD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bytes_i | input | NB*8 | Instruction bytes, byte 0 in the low bits |
| major_o | output | 4 | Major opcode |
| minor_o | output | 4 | Minor opcode |
| rd_o | output | 4 | Destination register |
| rs_o | output | 4 | Source register |
| rz_o | output | 4 | Index register |
| shamt_o | output | 4 | Index scale shift |
| len_o | output | 4 | Instruction length in bytes |
| cls_o | output | 10 | One-hot instruction class |
| imm_a_o | output | XLEN | First immediate, sign-extended |
| imm_b_o | output | XLEN | Second immediate, sign-extended |
| rd_port_o | output | 4 | Register index for read port A |
| reg_we_o | output | 1 | Register write enable |
| load_o | output | 1 | Memory load |
| store_o | output | 1 | Memory store |
| use_imm_o | output | 1 | Operand B from immediate |
| cond_o | output | 1 | Conditional control transfer |
| call_o | output | 1 | Call |
| ret_o | output | 1 | Return |
| stop_o | output | 1 | Stop |
| fu_sel_o | output | 4 | Result unit select |
| mul_signed_o | output | 1 | Signed multiply |
| shift_left_o | output | 1 | Left shift |
| shift_arith_o | output | 1 | Arithmetic shift |
| ag_src_o | output | 1 | Address term: source register |
| ag_idx_o | output | 1 | Address term: scaled index |
| ag_disp_o | output | 1 | Address term: displacement |
| illegal_o | output | 1 | Undefined major opcode |

## Verification
Several decisions are made from the same byte in the same evaluation, and they can collide. A memory move drives a load or store strobe and the address-generator enables at once. Address-compute forms switch both the read port and the immediate offset. Compare-and-branch asserts the condition flag, the displacement enable and the second immediate position together. The bench sweeps all 256 values of byte 0, each against three fills of the trailing bytes with different sign bits. For every vector it compares all outputs with a reference written from the requirement tables. This shows that the strobes raised together are each correct, and that every unrelated strobe stays low.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int unsigned NCLS = 10;

  typedef enum logic [3:0] {
    OP_RETSTOP = 4'h0, OP_RALU  = 4'h1, OP_RMOV = 4'h2, OP_RMEM = 4'h3,
    OP_CFLOW   = 4'h4, OP_IALU  = 4'h5, OP_IMOV = 4'h6, OP_IMEM = 4'h7,
    OP_ADR2    = 4'h8, OP_ADR3  = 4'h9, OP_ADR6 = 4'hA, OP_ADR7 = 4'hB,
    OP_ICBR    = 4'hF
  } major_e;

  typedef enum int unsigned {
    C_RETSTOP = 0, C_RALU = 1, C_RMOV = 2, C_RMEM = 3, C_CFLOW = 4,
    C_IALU = 5, C_IMOV = 6, C_IMEM = 7, C_ADR = 8, C_ICBR = 9
  } cls_idx_e;

  localparam logic [3:0] MN_STOP = 4'h0;
  localparam logic [3:0] MN_RET  = 4'h1;
  localparam logic [3:0] MN_MULU = 4'h4;
  localparam logic [3:0] MN_MULS = 4'h5;
  localparam logic [3:0] MN_SAL  = 4'hC;
  localparam logic [3:0] MN_SAR  = 4'hD;
  localparam logic [3:0] MN_SHR  = 4'hE;
  localparam logic [3:0] MN_CALL = 4'hE;
  localparam logic [3:0] MN_JMP  = 4'hF;

  localparam int unsigned FU_AGEN = 0;
  localparam int unsigned FU_MUL  = 1;
  localparam int unsigned FU_SHF  = 2;
  localparam int unsigned FU_ALU  = 3;
  localparam int unsigned NFU     = 4;
endpackage

// File: rtl/ivd_fields.sv
module ivd_fields
  import ivd_pkg::*;
(
  input  logic [23:0]     head_i,
  output logic [3:0]      major_o,
  output logic [3:0]      minor_o,
  output logic [3:0]      rd_o,
  output logic [3:0]      rs_o,
  output logic [3:0]      rz_o,
  output logic [3:0]      shamt_o,
  output logic [3:0]      len_o,
  output logic [NCLS-1:0] cls_o,
  output logic            illegal_o
);
  assign major_o = head_i[7:4];
  assign minor_o = head_i[3:0];
  assign rd_o    = head_i[15:12];
  assign rs_o    = head_i[11:8];
  assign rz_o    = head_i[23:20];
  assign shamt_o = head_i[19:16];

  always_comb begin
    cls_o     = '0;
    len_o     = 4'd0;
    illegal_o = 1'b0;
    case (major_o)
      OP_RETSTOP: begin cls_o[C_RETSTOP] = 1'b1; len_o = 4'd2;  end
      OP_RALU:    begin cls_o[C_RALU]    = 1'b1; len_o = 4'd2;  end
      OP_RMOV:    begin cls_o[C_RMOV]    = 1'b1; len_o = 4'd2;  end
      OP_RMEM:    begin cls_o[C_RMEM]    = 1'b1; len_o = 4'd2;  end
      OP_CFLOW:   begin cls_o[C_CFLOW]   = 1'b1; len_o = 4'd6;  end
      OP_IALU:    begin cls_o[C_IALU]    = 1'b1; len_o = 4'd6;  end
      OP_IMOV:    begin cls_o[C_IMOV]    = 1'b1; len_o = 4'd6;  end
      OP_IMEM:    begin cls_o[C_IMEM]    = 1'b1; len_o = 4'd6;  end
      OP_ADR2:    begin cls_o[C_ADR]     = 1'b1; len_o = 4'd2;  end
      OP_ADR3:    begin cls_o[C_ADR]     = 1'b1; len_o = 4'd3;  end
      OP_ADR6:    begin cls_o[C_ADR]     = 1'b1; len_o = 4'd6;  end
      OP_ADR7:    begin cls_o[C_ADR]     = 1'b1; len_o = 4'd7;  end
      OP_ICBR:    begin cls_o[C_ICBR]    = 1'b1; len_o = 4'd10; end
      default:    illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/ivd_imm.sv
module ivd_imm #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 32
) (
  input  logic [IMM_W-1:0] base_i,
  input  logic [IMM_W-1:0] alt_i,
  input  logic             use_alt_i,
  output logic [XLEN-1:0]  imm_o
);
  localparam int unsigned EXT_W = XLEN - IMM_W;
  logic [IMM_W-1:0] word;

  assign word = use_alt_i ? alt_i : base_i;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_o = {{EXT_W{word[IMM_W-1]}}, word};
    end else begin : g_noext
      assign imm_o = word[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/ivd_ctrl.sv
module ivd_ctrl
  import ivd_pkg::*;
(
  input  logic [NCLS-1:0] cls_i,
  input  logic [3:0]      minor_i,
  input  logic [3:0]      rd_i,
  input  logic [3:0]      rz_i,
  output logic [3:0]      rd_port_o,
  output logic            reg_we_o,
  output logic            load_o,
  output logic            store_o,
  output logic            use_imm_o,
  output logic            cond_o,
  output logic            call_o,
  output logic            ret_o,
  output logic            stop_o,
  output logic [NFU-1:0]  fu_sel_o,
  output logic            mul_signed_o,
  output logic            shift_left_o,
  output logic            shift_arith_o,
  output logic            ag_src_o,
  output logic            ag_idx_o,
  output logic            ag_disp_o
);
  logic is_adr, is_move, is_mem, is_arith, use_agen, is_mul, is_shf;

  assign is_adr   = cls_i[C_ADR];
  assign is_mem   = cls_i[C_RMEM] | cls_i[C_IMEM];
  assign is_move  = cls_i[C_RMOV] | cls_i[C_IMOV] | is_mem;
  assign is_arith = cls_i[C_RALU] | cls_i[C_IALU];
  assign use_agen = is_adr | is_move;

  assign load_o  = is_mem & ~minor_i[3];
  assign store_o = is_mem &  minor_i[3];

  assign cond_o  = (cls_i[C_CFLOW] | cls_i[C_ICBR]) &
                   (minor_i != MN_CALL) & (minor_i != MN_JMP);
  assign call_o  = cls_i[C_CFLOW] & (minor_i == MN_CALL);
  assign ret_o   = cls_i[C_RETSTOP] & (minor_i == MN_RET);
  assign stop_o  = cls_i[C_RETSTOP] & (minor_i == MN_STOP);

  assign use_imm_o = cls_i[C_IMOV] | cls_i[C_IALU] | cls_i[C_ICBR];
  assign rd_port_o = is_adr ? rz_i : rd_i;
  assign reg_we_o  = is_arith | is_adr | load_o | cls_i[C_RMOV] |
                     cls_i[C_IMOV] | call_o;

  // agen term enables come straight from minor bits
  assign ag_src_o  = (minor_i[0] & use_agen) | cls_i[C_RALU] | cls_i[C_CFLOW];
  assign ag_idx_o  =  minor_i[1] & use_agen;
  assign ag_disp_o = (minor_i[2] & use_agen) | cls_i[C_IALU] | cls_i[C_ICBR];

  assign is_mul = is_arith & ((minor_i == MN_MULU) | (minor_i == MN_MULS));
  assign is_shf = is_arith & ((minor_i == MN_SAL) | (minor_i == MN_SAR) |
                              (minor_i == MN_SHR));

  always_comb begin
    fu_sel_o = '0;
    fu_sel_o[FU_AGEN] = use_agen;
    fu_sel_o[FU_MUL]  = is_mul;
    fu_sel_o[FU_SHF]  = is_shf;
    fu_sel_o[FU_ALU]  = (is_arith | cond_o) & ~is_mul & ~is_shf;
  end

  assign mul_signed_o  = is_mul & (minor_i == MN_MULS);
  assign shift_left_o  = is_shf & (minor_i == MN_SAL);
  assign shift_arith_o = is_shf & ((minor_i == MN_SAL) | (minor_i == MN_SAR));
endmodule

// File: rtl/ivd_decoder.sv
module ivd_decoder
  import ivd_pkg::*;
#(
  parameter int unsigned NB    = 10,
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IMM_W = 32
) (
  input  logic [NB*8-1:0] bytes_i,
  output logic [3:0]      major_o,
  output logic [3:0]      minor_o,
  output logic [3:0]      rd_o,
  output logic [3:0]      rs_o,
  output logic [3:0]      rz_o,
  output logic [3:0]      shamt_o,
  output logic [3:0]      len_o,
  output logic [NCLS-1:0] cls_o,
  output logic [XLEN-1:0] imm_a_o,
  output logic [XLEN-1:0] imm_b_o,
  output logic [3:0]      rd_port_o,
  output logic            reg_we_o,
  output logic            load_o,
  output logic            store_o,
  output logic            use_imm_o,
  output logic            cond_o,
  output logic            call_o,
  output logic            ret_o,
  output logic            stop_o,
  output logic [NFU-1:0]  fu_sel_o,
  output logic            mul_signed_o,
  output logic            shift_left_o,
  output logic            shift_arith_o,
  output logic            ag_src_o,
  output logic            ag_idx_o,
  output logic            ag_disp_o,
  output logic            illegal_o
);
  localparam int unsigned OFS_BASE  = 2;
  localparam int unsigned OFS_ALT_A = 3;
  localparam int unsigned OFS_ALT_B = 6;

  ivd_fields u_fields (
    .head_i   (bytes_i[23:0]),
    .major_o  (major_o),
    .minor_o  (minor_o),
    .rd_o     (rd_o),
    .rs_o     (rs_o),
    .rz_o     (rz_o),
    .shamt_o  (shamt_o),
    .len_o    (len_o),
    .cls_o    (cls_o),
    .illegal_o(illegal_o)
  );

  ivd_imm #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm_a (
    .base_i   (bytes_i[OFS_BASE*8 +: IMM_W]),
    .alt_i    (bytes_i[OFS_ALT_A*8 +: IMM_W]),
    .use_alt_i(major_o == OP_ADR7),
    .imm_o    (imm_a_o)
  );

  ivd_imm #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm_b (
    .base_i   (bytes_i[OFS_BASE*8 +: IMM_W]),
    .alt_i    (bytes_i[OFS_ALT_B*8 +: IMM_W]),
    .use_alt_i(major_o == OP_ICBR),
    .imm_o    (imm_b_o)
  );

  ivd_ctrl u_ctrl (
    .cls_i        (cls_o),
    .minor_i      (minor_o),
    .rd_i         (rd_o),
    .rz_i         (rz_o),
    .rd_port_o    (rd_port_o),
    .reg_we_o     (reg_we_o),
    .load_o       (load_o),
    .store_o      (store_o),
    .use_imm_o    (use_imm_o),
    .cond_o       (cond_o),
    .call_o       (call_o),
    .ret_o        (ret_o),
    .stop_o       (stop_o),
    .fu_sel_o     (fu_sel_o),
    .mul_signed_o (mul_signed_o),
    .shift_left_o (shift_left_o),
    .shift_arith_o(shift_arith_o),
    .ag_src_o     (ag_src_o),
    .ag_idx_o     (ag_idx_o),
    .ag_disp_o    (ag_disp_o)
  );
endmodule

// File: rtl/ivd_decoder_chk.sv
module ivd_decoder_chk
  import ivd_pkg::*;
(
  input logic [3:0]      major_o,
  input logic [3:0]      len_o,
  input logic [NCLS-1:0] cls_o,
  input logic [3:0]      rd_port_o,
  input logic [3:0]      rz_o,
  input logic            reg_we_o,
  input logic            load_o,
  input logic            store_o,
  input logic            use_imm_o,
  input logic            cond_o,
  input logic [NFU-1:0]  fu_sel_o,
  input logic            mul_signed_o,
  input logic            shift_arith_o,
  input logic            ag_src_o,
  input logic            ag_idx_o,
  input logic            ag_disp_o,
  input logic            illegal_o
);
  always_comb begin
    p_len_legal_r2: assert (illegal_o || len_o == 4'd2 || len_o == 4'd3 ||
                            len_o == 4'd6 || len_o == 4'd7 || len_o == 4'd10);
    p_cls_onehot_r5: assert ($onehot0(cls_o) && (illegal_o || $countones(cls_o) == 1));
    p_ldst_excl_r6: assert (!(load_o && store_o));
    p_port_sel_r9: assert (!cls_o[C_ADR] || rd_port_o == rz_o);
    p_fu_onehot_r10: assert ($onehot0(fu_sel_o));
    p_illegal_quiet_r11: assert (!illegal_o ||
      (len_o == 4'd0 && cls_o == '0 && !reg_we_o && !load_o && !store_o &&
       !use_imm_o && !cond_o && fu_sel_o == '0 && !ag_src_o && !ag_idx_o &&
       !ag_disp_o));
    p_illegal_range_r11: assert (illegal_o == (major_o >= 4'hC && major_o <= 4'hE));
    p_mul_gate_r12: assert (!mul_signed_o || fu_sel_o[FU_MUL]);
    p_shf_gate_r12: assert (!shift_arith_o || fu_sel_o[FU_SHF]);
  end
endmodule

bind ivd_decoder ivd_decoder_chk u_chk (
  .major_o      (major_o),
  .len_o        (len_o),
  .cls_o        (cls_o),
  .rd_port_o    (rd_port_o),
  .rz_o         (rz_o),
  .reg_we_o     (reg_we_o),
  .load_o       (load_o),
  .store_o      (store_o),
  .use_imm_o    (use_imm_o),
  .cond_o       (cond_o),
  .fu_sel_o     (fu_sel_o),
  .mul_signed_o (mul_signed_o),
  .shift_arith_o(shift_arith_o),
  .ag_src_o     (ag_src_o),
  .ag_idx_o     (ag_idx_o),
  .ag_disp_o    (ag_disp_o),
  .illegal_o    (illegal_o)
);

// File: tb/ivd_decoder_tb.sv
module ivd_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 10;
  localparam int XLEN = 64;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NB*8-1:0] bytes;
  logic [3:0] major, minor, rd, rs, rz, shamt, len, rd_port;
  logic [9:0] cls;
  logic [XLEN-1:0] imm_a, imm_b;
  logic reg_we, load, store, use_imm, cond, call, ret, stop;
  logic [3:0] fu_sel;
  logic mul_s, shl, sha, ag_s, ag_z, ag_d, illegal;

  ivd_decoder #(.NB(NB), .XLEN(XLEN)) u_dut (
    .bytes_i(bytes), .major_o(major), .minor_o(minor), .rd_o(rd), .rs_o(rs),
    .rz_o(rz), .shamt_o(shamt), .len_o(len), .cls_o(cls), .imm_a_o(imm_a),
    .imm_b_o(imm_b), .rd_port_o(rd_port), .reg_we_o(reg_we), .load_o(load),
    .store_o(store), .use_imm_o(use_imm), .cond_o(cond), .call_o(call),
    .ret_o(ret), .stop_o(stop), .fu_sel_o(fu_sel), .mul_signed_o(mul_s),
    .shift_left_o(shl), .shift_arith_o(sha), .ag_src_o(ag_s), .ag_idx_o(ag_z),
    .ag_disp_o(ag_d), .illegal_o(illegal)
  );

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h bytes=%h", req, got, exp, bytes);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  function automatic logic [31:0] word_at(input logic [NB*8-1:0] b, input int ofs);
    return {b[(ofs+3)*8 +: 8], b[(ofs+2)*8 +: 8], b[(ofs+1)*8 +: 8], b[ofs*8 +: 8]};
  endfunction

  task automatic check_vec();
    logic [3:0] mj, mn;
    logic [9:0] e_cls;
    logic [3:0] e_len, e_fu;
    bit e_ill, adr, mem, mov, ari, agen, e_cond, e_call, e_load, e_mul, e_shf;
    mj = bytes[7:4];
    mn = bytes[3:0];
    e_cls = '0; e_len = 0; e_ill = 0;
    case (mj)
      4'h0: begin e_cls[0] = 1; e_len = 2; end
      4'h1: begin e_cls[1] = 1; e_len = 2; end
      4'h2: begin e_cls[2] = 1; e_len = 2; end
      4'h3: begin e_cls[3] = 1; e_len = 2; end
      4'h4: begin e_cls[4] = 1; e_len = 6; end
      4'h5: begin e_cls[5] = 1; e_len = 6; end
      4'h6: begin e_cls[6] = 1; e_len = 6; end
      4'h7: begin e_cls[7] = 1; e_len = 6; end
      4'h8: begin e_cls[8] = 1; e_len = 2; end
      4'h9: begin e_cls[8] = 1; e_len = 3; end
      4'hA: begin e_cls[8] = 1; e_len = 6; end
      4'hB: begin e_cls[8] = 1; e_len = 7; end
      4'hF: begin e_cls[9] = 1; e_len = 10; end
      default: e_ill = 1;
    endcase
    adr = e_cls[8];
    mem = (mj == 4'h3) || (mj == 4'h7);
    mov = mem || (mj == 4'h2) || (mj == 4'h6);
    ari = (mj == 4'h1) || (mj == 4'h5);
    agen = adr || mov;
    e_cond = ((mj == 4'h4) || (mj == 4'hF)) && mn != 4'hE && mn != 4'hF;
    e_call = (mj == 4'h4) && mn == 4'hE;
    e_load = mem && !mn[3];
    e_mul = ari && (mn == 4'h4 || mn == 4'h5);
    e_shf = ari && (mn >= 4'hC && mn <= 4'hE);
    e_fu = {(ari || e_cond) && !e_mul && !e_shf, e_shf, e_mul, agen};

    // R1 fields
    chk("R1 major", major, mj);
    chk("R1 minor", minor, mn);
    chk("R1 rd/rs", {rd, rs}, bytes[15:8]);
    chk("R1 rz/shamt", {rz, shamt}, bytes[23:16]);
    chk("R2 len", len, e_len);
    chk("R3 imm_a", imm_a, sx(word_at(bytes, mj == 4'hB ? 3 : 2)));
    chk("R4 imm_b", imm_b, sx(word_at(bytes, mj == 4'hF ? 6 : 2)));
    chk("R5 cls", cls, e_cls);
    chk("R6 ld/st", {load, store}, {e_load, mem && mn[3]});
    chk("R7 cond/call/ret/stop", {cond, call, ret, stop},
        {e_cond, e_call, mj == 4'h0 && mn == 4'h1, mj == 4'h0 && mn == 4'h0});
    chk("R8 agen enables", {ag_s, ag_z, ag_d},
        {(mn[0] && agen) || mj == 4'h1 || mj == 4'h4, mn[1] && agen,
         (mn[2] && agen) || mj == 4'h5 || mj == 4'hF});
    chk("R9 reg_we", reg_we, ari || adr || e_load || mj == 4'h2 || mj == 4'h6 || e_call);
    chk("R9 rd_port", rd_port, adr ? bytes[23:20] : bytes[15:12]);
    chk("R10 fu_sel", fu_sel, e_fu);
    chk("R10 use_imm", use_imm, mj == 4'h5 || mj == 4'h6 || mj == 4'hF);
    chk("R11 illegal", illegal, e_ill);
    chk("R12 mul/shift flags", {mul_s, shl, sha},
        {e_mul && mn == 4'h5, e_shf && mn == 4'hC, e_shf && (mn == 4'hC || mn == 4'hD)});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bytes = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // reset-state style check: all-zero bytes decode as stop, length 2
    chk("R7 stop on zero bytes", {stop, len}, {1'b1, 4'd2});
    for (int pat = 0; pat < 3; pat++) begin
      for (int b0 = 0; b0 < 256; b0++) begin
        @(negedge clk);
        bytes[7:0] = b0[7:0];
        for (int k = 1; k < NB; k++) begin
          logic [7:0] v;
          v = 8'((b0 * 7) + (pat * 53) + (k * 29));
          if (pat == 2) v = v ^ 8'h80;
          if (pat == 1) v = ~v;
          bytes[k*8 +: 8] = v;
        end
        #1;
        check_vec();
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule